// File: doc/BRIEF.md
# Four-Mode SPI Master

This block is a full-duplex serial master for a bus of up to `NUM_SLV` point-to-point slaves. Each command names one slave, a clock polarity and a clock phase, a transfer length between 1 and `MAX_BITS` bits, a transmit word and a clock divider. The block pulls that slave's active-low select low and toggles the serial clock. It shifts the transmit word out on `mosi` and collects `miso` at the same time. When the transfer ends it releases the select and presents the received word with a one-cycle done strobe.

The serial clock comes from the system clock. Each half period lasts `cmd_div + 1` system cycles. Polarity and phase are taken afresh from every command, so consecutive transfers may use different modes for different slaves. The slave returns no acknowledge. The transfer is complete once the requested number of bits has been clocked.

Top module: `spi_master_ctl`

## Requirements
- R1: During and right after synchronous reset all `cs_n` bits are 1, `sclk` is 0, `rx_done` is 0, `rx_data` is 0 and `cmd_ready` is 1.
- R2: At most one `cs_n` bit is 0 at any time. During a transfer the low bit is `cs_n[cmd_slave]`, with `cmd_slave` read as a binary index.
- R3: From the cycle after a command is accepted, `sclk` sits at that command's `cmd_cpol`. It holds that level whenever no select is low, and it is back at that level when the select rises.
- R4: With `cmd_cpha`=0, `mosi` shows the first bit before the first `sclk` edge. Data is sampled on edges 1, 3, 5, … (counting from 1), and the next bit is launched on edges 2, 4, ….
- R5: With `cmd_cpha`=1, a bit is launched on edges 1, 3, … and sampled on edges 2, 4, ….
- R6: A transfer of n bits produces exactly 2n `sclk` edges. `cmd_nbits` values 1..32 give n = `cmd_nbits`. The values 0 and anything above 32 give n = 32.
- R7: Bits go out and come in MSB first. `cmd_tx[n-1:0]` is sent and the bits of `cmd_tx` above n-1 are ignored. The received bits land in `rx_data[n-1:0]` and the upper bits of `rx_data` read 0.
- R8: With H = `cmd_div`+1, the select falls one cycle after acceptance. The first `sclk` edge comes H cycles after the select falls, and further edges follow every H cycles. The select stays low for exactly H·(2n+1) cycles, and `sclk` does not change in a cycle where the select changes.
- R9: `rx_done` is high for exactly one cycle, the one in which the select returns high. `rx_data` is valid in that cycle and holds until the next done strobe.
- R10: `cmd_ready` is 0 from the cycle after acceptance until the select returns high. A `cmd_valid` seen while `cmd_ready` is 0 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Block idle; a command is taken when both are high |
| cmd_slave | input | SLV_W | Index of the slave to select |
| cmd_cpol | input | 1 | Clock idle level |
| cmd_cpha | input | 1 | 0: sample on odd edges, 1: sample on even edges |
| cmd_nbits | input | CNT_W | Transfer length in bits |
| cmd_tx | input | MAX_BITS | Transmit word, right-aligned |
| cmd_div | input | DIV_W | Half period minus one, in system cycles |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to the slave |
| miso | input | 1 | Serial data from the slave |
| cs_n | output | NUM_SLV | Active-low selects, one per slave |
| rx_data | output | MAX_BITS | Received word, right-aligned |
| rx_done | output | 1 | One-cycle strobe marking `rx_data` valid |

## Verification
Counting from the clock edge that accepts a command, the select falls one edge later. The first serial clock edge follows H cycles after that, and the select rises together with `rx_done` H·(2n+1) cycles after it fell. The bench numbers each falling-edge sample from the acceptance edge, and it compares the sample index at which each of these events first appears against those formulas. It acts as the slave itself: it reacts to every `sclk` change seen at a falling system edge, records `mosi` on sampling edges and changes `miso` only on launch edges, so the data checks rest on the mode rules rather than on fixed cycle numbers.

// File: rtl/spim_pkg.sv
`timescale 1ns/1ps
package spim_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_SETUP = 3'd1,
        ST_LEAD  = 3'd2,
        ST_XFER  = 3'd3,
        ST_TRAIL = 3'd4
    } spim_state_e;

    typedef struct packed {
        logic cpol;
        logic cpha;
    } spim_mode_t;

    // Length actually clocked: out-of-range requests fall back to the maximum.
    function automatic int spim_eff_bits(input int req, input int max_bits);
        return (req < 1 || req > max_bits) ? max_bits : req;
    endfunction

    // An edge samples when its parity (counting from 0) equals the phase bit.
    function automatic logic spim_is_sample(input logic edge_lsb, input logic cpha);
        return edge_lsb == cpha;
    endfunction

endpackage

// File: rtl/spim_halfper.sv
`timescale 1ns/1ps
module spim_halfper #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt_q;

    assign tick = run && (cnt_q == div);

    always_ff @(posedge clk) begin
        if (rst || !run || tick) cnt_q <= '0;
        else                     cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/spim_shift.sv
`timescale 1ns/1ps
module spim_shift #(
    parameter int MAX_BITS = 32,
    parameter int CNT_W    = 6
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                load,
    input  logic [MAX_BITS-1:0] tx_word,
    input  logic [CNT_W-1:0]    nbits,
    input  logic                launch,
    input  logic                sample,
    input  logic                miso,
    output logic                mosi,
    output logic [MAX_BITS-1:0] rx_word
);
    logic [MAX_BITS-1:0] tx_q;
    logic [MAX_BITS-1:0] rx_q;
    logic [CNT_W-1:0]    align;

    // Left-align so the current bit is always the top one.
    assign align   = CNT_W'(MAX_BITS) - nbits;
    assign mosi    = tx_q[MAX_BITS-1];
    assign rx_word = rx_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_q <= '0;
            rx_q <= '0;
        end else if (load) begin
            tx_q <= tx_word << align;
            rx_q <= '0;
        end else begin
            if (launch) tx_q <= {tx_q[MAX_BITS-2:0], 1'b0};
            if (sample) rx_q <= {rx_q[MAX_BITS-2:0], miso};
        end
    end
endmodule

// File: rtl/spim_csel.sv
`timescale 1ns/1ps
module spim_csel #(
    parameter int NUM_SLV = 4,
    parameter int SLV_W   = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             grab,
    input  logic             drop,
    input  logic [SLV_W-1:0] idx,
    output logic [NUM_SLV-1:0] cs_n
);
    genvar i;
    generate
        for (i = 0; i < NUM_SLV; i++) begin : g_sel
            logic sel_n_q;
            always_ff @(posedge clk) begin
                if (rst || drop) sel_n_q <= 1'b1;
                else if (grab)   sel_n_q <= (idx != SLV_W'(i));
            end
            assign cs_n[i] = sel_n_q;
        end
    endgenerate
endmodule

// File: rtl/spi_master_ctl.sv
`timescale 1ns/1ps
module spi_master_ctl
    import spim_pkg::*;
#(
    parameter int NUM_SLV  = 4,
    parameter int MAX_BITS = 32,
    parameter int DIV_W    = 8,
    localparam int SLV_W   = (NUM_SLV > 1) ? $clog2(NUM_SLV) : 1,
    localparam int CNT_W   = $clog2(MAX_BITS + 1),
    localparam int EDGE_W  = CNT_W + 1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                cmd_valid,
    output logic                cmd_ready,
    input  logic [SLV_W-1:0]    cmd_slave,
    input  logic                cmd_cpol,
    input  logic                cmd_cpha,
    input  logic [CNT_W-1:0]    cmd_nbits,
    input  logic [MAX_BITS-1:0] cmd_tx,
    input  logic [DIV_W-1:0]    cmd_div,
    output logic                sclk,
    output logic                mosi,
    input  logic                miso,
    output logic [NUM_SLV-1:0]  cs_n,
    output logic [MAX_BITS-1:0] rx_data,
    output logic                rx_done
);
    spim_state_e         st_q;
    spim_mode_t          mode_q;
    logic [SLV_W-1:0]    idx_q;
    logic [DIV_W-1:0]    div_q;
    logic [CNT_W-1:0]    nb_q;
    logic [EDGE_W-1:0]   edge_q;
    logic                sclk_q;
    logic                done_q;
    logic [MAX_BITS-1:0] rxd_q;

    logic                accept;
    logic                run;
    logic                tick;
    logic                edge_ev;
    logic                last_edge;
    logic                smp;
    logic                lau;
    logic                release_cs;
    logic [CNT_W-1:0]    nb_eff;
    logic [MAX_BITS-1:0] rx_word;

    assign cmd_ready  = (st_q == ST_IDLE);
    assign accept     = cmd_valid && cmd_ready;
    assign nb_eff     = CNT_W'(spim_eff_bits(int'(cmd_nbits), MAX_BITS));
    assign run        = (st_q == ST_LEAD) || (st_q == ST_XFER) || (st_q == ST_TRAIL);
    assign edge_ev    = tick && ((st_q == ST_LEAD) || (st_q == ST_XFER));
    assign last_edge  = (edge_q == (EDGE_W'({nb_q, 1'b0}) - EDGE_W'(1)));
    assign smp        = edge_ev && spim_is_sample(edge_q[0], mode_q.cpha);
    assign lau        = edge_ev && !spim_is_sample(edge_q[0], mode_q.cpha)
                        && (edge_q != '0);
    assign release_cs = tick && (st_q == ST_TRAIL);

    spim_halfper #(.DIV_W(DIV_W)) u_halfper (
        .clk  (clk),
        .rst  (rst),
        .run  (run),
        .div  (div_q),
        .tick (tick)
    );

    spim_shift #(.MAX_BITS(MAX_BITS), .CNT_W(CNT_W)) u_shift (
        .clk     (clk),
        .rst     (rst),
        .load    (accept),
        .tx_word (cmd_tx),
        .nbits   (nb_eff),
        .launch  (lau),
        .sample  (smp),
        .miso    (miso),
        .mosi    (mosi),
        .rx_word (rx_word)
    );

    spim_csel #(.NUM_SLV(NUM_SLV), .SLV_W(SLV_W)) u_csel (
        .clk  (clk),
        .rst  (rst),
        .grab (st_q == ST_SETUP),
        .drop (release_cs),
        .idx  (idx_q),
        .cs_n (cs_n)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_IDLE;
            mode_q <= '0;
            idx_q  <= '0;
            div_q  <= '0;
            nb_q   <= '0;
            edge_q <= '0;
            sclk_q <= 1'b0;
            done_q <= 1'b0;
            rxd_q  <= '0;
        end else begin
            done_q <= 1'b0;
            unique case (st_q)
                ST_IDLE: begin
                    if (accept) begin
                        mode_q <= '{cpol: cmd_cpol, cpha: cmd_cpha};
                        idx_q  <= cmd_slave;
                        div_q  <= cmd_div;
                        nb_q   <= nb_eff;
                        edge_q <= '0;
                        sclk_q <= cmd_cpol;
                        st_q   <= ST_SETUP;
                    end
                end
                ST_SETUP: st_q <= ST_LEAD;
                ST_LEAD, ST_XFER: begin
                    if (edge_ev) begin
                        sclk_q <= ~sclk_q;
                        edge_q <= edge_q + 1'b1;
                        if (st_q == ST_LEAD) st_q <= ST_XFER;
                        else if (last_edge)  st_q <= ST_TRAIL;
                    end
                end
                ST_TRAIL: begin
                    if (tick) begin
                        done_q <= 1'b1;
                        rxd_q  <= rx_word;
                        st_q   <= ST_IDLE;
                    end
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    assign sclk    = sclk_q;
    assign rx_done = done_q;
    assign rx_data = rxd_q;
endmodule

// File: rtl/spim_checker.sv
`timescale 1ns/1ps
module spim_checker #(
    parameter int NUM_SLV = 4
) (
    input logic               clk,
    input logic               rst,
    input logic               cmd_valid,
    input logic               cmd_ready,
    input logic               sclk,
    input logic [NUM_SLV-1:0] cs_n,
    input logic               rx_done
);
    a_r1_reset_idle: assert property (@(posedge clk)
        $past(rst) |-> ((&cs_n) && !rx_done && cmd_ready && !sclk));

    a_r2_one_select: assert property (@(posedge clk) disable iff (rst)
        $countones(~cs_n) <= 1);

    a_r3_clock_parked: assert property (@(posedge clk) disable iff (rst)
        (sclk != $past(sclk)) |-> (!(&cs_n) || $past(cmd_valid && cmd_ready)));

    a_r8_quiet_select_edge: assert property (@(posedge clk) disable iff (rst)
        (cs_n != $past(cs_n)) |-> (sclk == $past(sclk)));

    a_r9_done_released: assert property (@(posedge clk) disable iff (rst)
        rx_done |-> (&cs_n));

    a_r9_done_single: assert property (@(posedge clk) disable iff (rst)
        rx_done |=> !rx_done);

    a_r10_busy_blocks: assert property (@(posedge clk) disable iff (rst)
        !(&cs_n) |-> !cmd_ready);
endmodule

bind spi_master_ctl spim_checker #(.NUM_SLV(NUM_SLV)) u_spim_checker (
    .clk       (clk),
    .rst       (rst),
    .cmd_valid (cmd_valid),
    .cmd_ready (cmd_ready),
    .sclk      (sclk),
    .cs_n      (cs_n),
    .rx_done   (rx_done)
);

// File: tb/test_spi_master_ctl.sv
`timescale 1ns/1ps
module test_spi_master_ctl;
    localparam int NS = 4;
    localparam int MB = 32;
    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cmd_valid = 1'b0;
    logic          cmd_ready;
    logic [1:0]    cmd_slave = '0;
    logic          cmd_cpol = 1'b0;
    logic          cmd_cpha = 1'b0;
    logic [5:0]    cmd_nbits = '0;
    logic [MB-1:0] cmd_tx = '0;
    logic [DW-1:0] cmd_div = '0;
    logic          sclk;
    logic          mosi;
    logic          miso = 1'b0;
    logic [NS-1:0] cs_n;
    logic [MB-1:0] rx_data;
    logic          rx_done;

    int n_chk  = 0;
    int n_fail = 0;
    bit ended  = 1'b0;

    always #2 clk = ~clk;

    spi_master_ctl #(.NUM_SLV(NS), .MAX_BITS(MB), .DIV_W(DW)) i_spi_master_ctl (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_slave(cmd_slave), .cmd_cpol(cmd_cpol), .cmd_cpha(cmd_cpha),
        .cmd_nbits(cmd_nbits), .cmd_tx(cmd_tx), .cmd_div(cmd_div),
        .sclk(sclk), .mosi(mosi), .miso(miso), .cs_n(cs_n),
        .rx_data(rx_data), .rx_done(rx_done)
    );

    task automatic check(input string req, input string what,
                         input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    // One transfer with the bench acting as the slave.
    task automatic run_xfer(input int slv, input bit pol, input bit pha,
                            input int nb_req, input logic [MB-1:0] tx,
                            input int dv, input logic [MB-1:0] sw,
                            input bit poke, input string dreq);
        int n = (nb_req < 1 || nb_req > MB) ? MB : nb_req;
        int h = dv + 1;
        longint mask = (n == MB) ? 64'hFFFF_FFFF : ((64'd1 << n) - 1);
        logic [NS-1:0] exp_cs = ~(NS'(1) << slv);
        logic [MB-1:0] got = '0;
        logic [MB-1:0] held;
        int c = 1, k = 0, lc = 0, first_low = 0, low_cnt = 0;
        int sel_bad = 0, first_edge = 0, done_c = 0, idle_bad = 0;
        logic prev;

        @(negedge clk);
        check("R10", "ready before command", cmd_ready, 1);
        cmd_slave = 2'(slv); cmd_cpol = pol; cmd_cpha = pha;
        cmd_nbits = 6'(nb_req); cmd_tx = tx; cmd_div = DW'(dv);
        cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        miso = 1'b0;
        check("R3", "clock parked at polarity", sclk, pol);
        check("R10", "ready dropped after accept", cmd_ready, 0);
        prev = sclk;
        while (done_c == 0 && c < 20000) begin
            if (poke && c == 4) begin
                cmd_valid = 1'b1;
                cmd_slave = 2'((slv + 1) % NS);
            end
            if (poke && c == 5) cmd_valid = 1'b0;
            if (cs_n != '1) begin
                low_cnt++;
                if (first_low == 0) begin
                    first_low = c;
                    if (!pha) begin miso = sw[n-1]; lc = 1; end
                end
                if (cs_n != exp_cs) sel_bad++;
                if (sclk != prev) begin
                    if (first_edge == 0) first_edge = c;
                    if ((k % 2) == int'(pha)) got = {got[MB-2:0], mosi};
                    else if (lc < n) begin miso = sw[n-1-lc]; lc++; end
                    k++;
                end
            end else if (sclk != prev && c > 1) begin
                idle_bad++;
            end
            if (rx_done) done_c = c;
            prev = sclk;
            if (done_c == 0) begin
                @(negedge clk);
                c++;
            end
        end
        check("R8", "select falls one cycle after accept", first_low, 2);
        check("R8", "first edge after one half period", first_edge, first_low + h);
        check("R8", "select low time", low_cnt, h * (2 * n + 1));
        check("R9", "done with select release", done_c, first_low + h * (2 * n + 1));
        check("R6", "edge count", k, 2 * n);
        check("R2", "wrong select pattern cycles", sel_bad, 0);
        check("R3", "clock moved while idle", idle_bad, 0);
        check("R3", "clock back at idle level", sclk, pol);
        check(dreq, "bits seen by slave", got & mask, tx & mask);
        check("R7", "received word", rx_data, sw & mask);
        held = rx_data;
        @(negedge clk);
        check("R9", "done lasts one cycle", rx_done, 0);
        check("R9", "received word held", rx_data, held);
        check("R10", "late command ignored, selects high", cs_n, {NS{1'b1}});
        check("R10", "ready again", cmd_ready, 1);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1", "selects after reset", cs_n, {NS{1'b1}});
        check("R1", "clock after reset", sclk, 0);
        check("R1", "done after reset", rx_done, 0);
        check("R1", "data after reset", rx_data, 0);
        check("R1", "ready after reset", cmd_ready, 1);
        rst = 1'b0;
    endtask

    task automatic t_mode0_byte();
        run_xfer(0, 1'b0, 1'b0, 8, 32'h0000_00A5, 1, 32'h0000_003C, 1'b0, "R4");
    endtask

    task automatic t_mode1_odd_len();
        run_xfer(1, 1'b0, 1'b1, 12, 32'h0000_0B2D, 0, 32'h0000_0E71, 1'b0, "R5");
    endtask

    task automatic t_mode2_single_bit();
        run_xfer(2, 1'b1, 1'b0, 1, 32'h0000_0001, 2, 32'h0000_0001, 1'b0, "R4");
    endtask

    task automatic t_mode3_full_word();
        run_xfer(3, 1'b1, 1'b1, 32, 32'hC3A5_0F96, 0, 32'h5A1E_F00D, 1'b0, "R5");
    endtask

    task automatic t_upper_bits_ignored();
        run_xfer(2, 1'b0, 1'b1, 5, 32'hFFFF_FF0A, 3, 32'hFFFF_FF15, 1'b0, "R7");
    endtask

    task automatic t_zero_length_is_max();
        run_xfer(1, 1'b1, 1'b0, 0, 32'h8000_0001, 0, 32'h1234_5678, 1'b0, "R6");
    endtask

    task automatic t_busy_command();
        run_xfer(0, 1'b1, 1'b1, 6, 32'h0000_0029, 1, 32'h0000_0016, 1'b1, "R10");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        t_reset();
        t_mode0_byte();
        t_mode1_odd_len();
        t_mode2_single_bit();
        t_mode3_full_word();
        t_upper_bits_ignored();
        t_zero_length_is_max();
        t_busy_command();
        t_mode0_byte();
        finish_run();
    end
endmodule